// File: doc/BRIEF.md
# Platform Interrupt Controller Claim Unit

This block gathers a set of interrupt source lines and raises one interrupt request line per hart context. Software programs it over a plain 32-bit read/write register bus. Each source has a priority register. Each context has an enable bit vector, a threshold register and a claim/complete register. For every context the block continuously picks the best eligible source. A source is eligible when it is pending, enabled for that context, and its priority is strictly above the context's threshold. Among eligible sources the highest priority wins, and the lower ID breaks a tie.

Service is a two-step handshake on one register per context. A read of the claim register returns the winning source ID and takes that source out of arbitration in the same cycle. A later write of the same ID to that register finishes service and lets the source's gateway forward a new request. Writing priority 0 masks a source. A threshold of all ones (7 with 3-bit priorities) blocks a context completely. Source ID 0 does not exist, and a claim read returns 0 when nothing is eligible.

Each source's gateway is either level-high or rising-edge, chosen per source by a parameter. Bus reads are combinational in the request cycle. Writes, claims and completions take effect at the following clock edge.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset every priority, enable and threshold register reads 0, every claim read returns 0 and all interrupt outputs are low.
- R2: Source ID 0 has no state: the word at address 0x0 reads 0 and ignores writes, and bit 0 of every enable word reads 0 whatever is written.
- R3: The priority of source i (1 to 31) is the word at 4*i. Only the low 3 bits are stored, and the upper bits read 0.
- R4: The enable vector of context c is the word at 0x2000 + 0x80*c. Bit i enables source i.
- R5: The threshold of context c is the word at 0x200000 + 0x1000*c, holding 3 bits. The claim/complete register is the word 4 bytes above it. Other addresses read 0.
- R6: Interrupt output c is high exactly when some source is pending, enabled for c, and has a priority strictly greater than the threshold of c. A threshold of 7 therefore blocks everything, and priority 0 never interrupts.
- R7: A claim read returns the eligible source with the highest priority. On equal priority the lower ID is returned, and 0 is returned when no source is eligible.
- R8: A claim read clears the returned source's pending bit at that clock edge. The source then raises no request until it is completed, so repeated claim reads move on to other sources and finally return 0.
- R9: Writing an in-service source ID to any context's claim register completes that source, even while the source is disabled in every context.
- R10: A completion write whose value is not the ID of a source in service (0, a pending-but-unclaimed ID, an idle ID or an out-of-range value) changes nothing.
- R11: Sources 1 to 15 are level-high. After completion a source still held high becomes pending again, and one that has gone low does not.
- R12: Sources 16 to 31 are rising-edge. Only a low-to-high transition makes the source pending. An input held high after completion raises nothing, and an edge seen while the source is in service is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 31 | Source lines; bit k is source ID k+1 |
| bus_req | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_out | output | 2 | Interrupt request, one per context |

## Verification
The bench sweeps every priority, enable and threshold register with the unused bits set, and every threshold from 0 to 7 against a fixed mix of priorities. A threshold compare written as greater-or-equal would raise an interrupt at threshold 7, or hand out a source whose priority equals the threshold. It drains a full set of level sources through repeated claims, with tied priorities. A tie rule that favours the higher ID, or a claim that fails to clear pending, would show up as a wrong ID or as one ID returned twice. It also aims at the handshake edges. A completion gated by the enable bits would leave a source stuck in service. Stray completion values must be ignored, or a source would be released early. An edge gateway that re-fires on a held input or on an edge seen during service would return a second claim that should be 0.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [31:0] THR_OFS    = 32'h0000_0000;
  localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;

  function automatic logic [31:0] prio_addr(input int unsigned id);
    return PRIO_BASE + 32'(4 * id);
  endfunction

  function automatic logic [31:0] en_addr(input int unsigned ctx, input int unsigned word);
    return EN_BASE + 32'(ctx) * EN_STRIDE + 32'(4 * word);
  endfunction

  function automatic logic [31:0] thr_addr(input int unsigned ctx);
    return CTX_BASE + 32'(ctx) * CTX_STRIDE + THR_OFS;
  endfunction

  function automatic logic [31:0] claim_addr(input int unsigned ctx);
    return CTX_BASE + 32'(ctx) * CTX_STRIDE + CLAIM_OFS;
  endfunction

endpackage

// File: rtl/icc_gateway.sv
module icc_gateway
  import icc_pkg::*;
#(
  parameter trig_e MODE = TRIG_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic cmpl_i,
  output logic pend_o,
  output logic busy_o
);

  logic req;
  logic pend_q, pend_d;
  logic busy_q, busy_d;

  if (MODE == TRIG_EDGE) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= src_i;
    end
    assign req = src_i & ~prev_q;
  end else begin : g_level
    assign req = src_i;
  end

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else if (cmpl_i && busy_q) begin
      busy_d = 1'b0;
    end else if (!busy_q && req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1]             en_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [ID_W-1:0]              best_id_o,
  output logic                         req_o
);

  logic [PRIO_W-1:0] best_p;

  // Scan from the top ID down; ">=" lets a lower ID take over on a tie.
  always_comb begin
    best_id_o = '0;
    best_p    = '0;
    for (int s = NUM_SRC; s >= 1; s--) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) && (prio_i[s] >= best_p)) begin
        best_id_o = ID_W'(s);
        best_p    = prio_i[s];
      end
    end
    req_o = (best_id_o != '0);
  end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import icc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22,
  parameter logic [NUM_SRC:1] EDGE_MASK = {{(NUM_SRC - NUM_SRC/2){1'b1}}, {(NUM_SRC/2){1'b0}}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CTX-1:0] irq_out
);

  localparam int ID_W     = $clog2(NUM_SRC + 1);
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;

  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q, en_d;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q, thr_d;

  logic [NUM_SRC:1] pend_vec, busy_vec, claim_vec, cmpl_vec;
  logic [NUM_CTX-1:0][ID_W-1:0] best_id;

  logic        rd_en, wr_en;
  logic [31:0] addr32;
  logic [EN_BITS-1:0] ew;

  assign rd_en  = bus_req & ~bus_we;
  assign wr_en  = bus_req &  bus_we;
  assign addr32 = 32'(bus_addr);

  // Source gateways
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    icc_gateway #(.MODE(trig_e'(EDGE_MASK[s]))) u_gw (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_in[s-1]),
      .claim_i(claim_vec[s]),
      .cmpl_i (cmpl_vec[s]),
      .pend_o (pend_vec[s]),
      .busy_o (busy_vec[s])
    );
  end

  // Per-context arbitration
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    icc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .pend_i   (pend_vec),
      .en_i     (en_q[c]),
      .prio_i   (prio_q),
      .thr_i    (thr_q[c]),
      .best_id_o(best_id[c]),
      .req_o    (irq_out[c])
    );
  end

  // Register decode, read mux and handshake strobes
  always_comb begin
    prio_d    = prio_q;
    en_d      = en_q;
    thr_d     = thr_q;
    bus_rdata = '0;
    claim_vec = '0;
    cmpl_vec  = '0;
    ew        = '0;

    for (int s = 1; s <= NUM_SRC; s++) begin
      if (addr32 == prio_addr(s)) begin
        bus_rdata = 32'(prio_q[s]);
        if (wr_en) prio_d[s] = bus_wdata[PRIO_W-1:0];
      end
    end

    for (int c = 0; c < NUM_CTX; c++) begin
      for (int w = 0; w < EN_WORDS; w++) begin
        if (addr32 == en_addr(c, w)) begin
          ew        = EN_BITS'({en_q[c], 1'b0});
          bus_rdata = ew[32*w +: 32];
          if (wr_en) begin
            ew[32*w +: 32] = bus_wdata;
            en_d[c]        = ew[NUM_SRC:1];
          end
        end
      end

      if (addr32 == thr_addr(c)) begin
        bus_rdata = 32'(thr_q[c]);
        if (wr_en) thr_d[c] = bus_wdata[PRIO_W-1:0];
      end

      if (addr32 == claim_addr(c)) begin
        bus_rdata = 32'(best_id[c]);
        for (int s = 1; s <= NUM_SRC; s++) begin
          if (rd_en && (best_id[c] == ID_W'(s))) claim_vec[s] = 1'b1;
          if (wr_en && (bus_wdata == 32'(s)))     cmpl_vec[s]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_req,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_CTX-1:0]            irq_out,
  input logic [NUM_SRC:1]              claim_vec,
  input logic [NUM_SRC:1]              cmpl_vec,
  input logic [NUM_SRC:1]              pend_vec,
  input logic [NUM_SRC:1]              busy_vec,
  input logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q
);

  AST_SRC0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == '0) |-> (bus_rdata == 32'h0)); // R2

  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec)); // R7

  AST_CLAIM_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & $past(claim_vec)) == '0)); // R8

  AST_NO_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & busy_vec) == '0)); // R8

  AST_RELEASE_NEEDS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(busy_vec) & ~busy_vec & ~$past(cmpl_vec)) == '0)); // R10

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
    AST_THR_MAX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (&thr_q[c]) |-> !irq_out[c]); // R6

    AST_EMPTY_CLAIM_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && (32'(bus_addr) == 32'h0020_0004 + 32'(c) * 32'h1000)
       && bus_rdata == 32'h0) |-> !irq_out[c]); // R7
  end

endmodule

bind irq_claim_ctrl icc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out),
  .claim_vec(claim_vec),
  .cmpl_vec (cmpl_vec),
  .pend_vec (pend_vec),
  .busy_vec (busy_vec),
  .thr_q    (thr_q)
);

// File: tb/tb_irq_claim_ctrl.sv
`timescale 1ns/1ps
module tb_irq_claim_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int vecs = 0;
  int errs = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  irq_claim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_req(req), .bus_we(we),
    .bus_addr(addr[21:0]), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  function automatic logic [31:0] a_prio(int s); return 32'(4 * s); endfunction
  function automatic logic [31:0] a_en(int c);   return 32'h2000 + 32'(c) * 32'h80; endfunction
  function automatic logic [31:0] a_thr(int c);  return 32'h20_0000 + 32'(c) * 32'h1000; endfunction
  function automatic logic [31:0] a_clm(int c);  return a_thr(c) + 32'h4; endfunction

  // priority pattern programmed into every source
  function automatic int pval(int s); return (s * 3) % 8; endfunction

  // expected winner: highest priority above threshold, lowest ID on a tie
  function automatic int best(logic [31:0] pm, logic [31:0] em, int thr);
    int id = 0;
    int bp = -1;
    for (int s = 1; s <= 31; s++)
      if (pm[s] && em[s] && pval(s) > thr && pval(s) > bp) begin
        id = s;
        bp = pval(s);
      end
    return id;
  endfunction

  task automatic chk(string tag, logic [31:0] g, logic [31:0] e);
    vecs++;
    if (g !== e) begin
      errs++;
      $display("FAIL %s got %h expected %h", tag, g, e);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic set_src(logic [30:0] v); @(negedge clk); src = v; endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] pm;
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R1: reset state
    chk("R1 irq", 32'(irq), 32'h0);
    for (int s = 1; s <= 31; s++) begin rd(a_prio(s), got); chk("R1 prio", got, 0); end
    for (int c = 0; c < 2; c++) begin
      rd(a_en(c), got);  chk("R1 enable", got, 0);
      rd(a_thr(c), got); chk("R1 threshold", got, 0);
      rd(a_clm(c), got); chk("R1 claim", got, 0);
    end

    // R2: source 0 has no state
    wr(32'h0, 32'hFFFF_FFFF);
    rd(32'h0, got); chk("R2 prio0", got, 0);

    // R3: priority words, 3 stored bits
    for (int s = 1; s <= 31; s++) wr(a_prio(s), 32'hFFFF_FFF8 | 32'(pval(s)));
    for (int s = 1; s <= 31; s++) begin rd(a_prio(s), got); chk("R3 prio", got, 32'(pval(s))); end

    // R4 / R2: enable words, bit 0 tied low
    for (int c = 0; c < 2; c++) begin
      wr(a_en(c), 32'hFFFF_FFFF);
      rd(a_en(c), got); chk("R4 R2 enable", got, 32'hFFFF_FFFE);
    end

    // R5: threshold width and unmapped words
    for (int c = 0; c < 2; c++) begin
      wr(a_thr(c), 32'hFFFF_FFFA);
      rd(a_thr(c), got); chk("R5 threshold", got, 32'h2);
    end
    wr(a_thr(0) + 32'h8, 32'hFFFF_FFFF);
    rd(a_thr(0) + 32'h8, got); chk("R5 unmapped", got, 0);

    // R6 / R7: drain level sources 1..15 through context 0
    wr(a_en(1), 32'h0);
    wr(a_thr(0), 0);
    wr(a_thr(1), 7);
    set_src(31'h0000_7FFF);
    idle();
    chk("R6 irq0 raised", 32'(irq[0]), 1);
    chk("R6 irq1 threshold 7", 32'(irq[1]), 0);
    pm = 32'h0000_FFFE;
    for (int k = 0; k < 16; k++) begin
      rd(a_clm(0), got);
      e = best(pm, 32'hFFFF_FFFE, 0);
      chk("R7 R8 claim order", got, 32'(e));
      if (e != 0) pm[e] = 1'b0;
    end
    chk("R6 only prio0 left", 32'(irq[0]), 0);
    for (int s = 1; s <= 15; s++) wr(a_clm(0), 32'(s));
    pm = 32'h0000_FFFE;
    idle();

    // R6 / R7: threshold sweep
    for (int t = 0; t < 8; t++) begin
      wr(a_thr(0), 32'(t));
      e = best(pm, 32'hFFFF_FFFE, t);
      chk("R6 irq vs threshold", 32'(irq[0]), (e != 0) ? 32'h1 : 32'h0);
      rd(a_clm(0), got);
      chk("R7 claim vs threshold", got, 32'(e));
      if (e != 0) wr(a_clm(0), 32'(e));
    end

    // R4 / R7: context 1 sees odd sources only
    wr(a_en(1), 32'hAAAA_AAAA);
    wr(a_thr(1), 2);
    wr(a_thr(0), 7);
    idle();
    chk("R4 irq1", 32'(irq[1]), 1);
    chk("R6 irq0 blocked", 32'(irq[0]), 0);
    e = best(pm, 32'hAAAA_AAAA, 2);
    rd(a_clm(1), got); chk("R4 R7 ctx1 claim", got, 32'(e));
    wr(a_clm(1), 32'(e));

    // R8: single source, repeated claim
    wr(a_en(1), 0);
    wr(a_en(0), 32'h1 << 4);
    wr(a_thr(0), 0);
    rd(a_clm(0), got); chk("R8 first claim", got, 4);
    rd(a_clm(0), got); chk("R8 second claim", got, 0);
    chk("R8 irq low", 32'(irq[0]), 0);

    // R10: stray completions
    wr(a_clm(0), 3);
    wr(a_clm(0), 0);
    wr(a_clm(0), 31);
    wr(a_clm(0), 32'h104);
    rd(a_clm(0), got); chk("R10 still in service", got, 0);

    // R9: completion while disabled
    wr(a_en(0), 0);
    wr(a_clm(0), 4);
    wr(a_en(0), 32'h1 << 4);
    rd(a_clm(0), got); chk("R9 reclaim", got, 4);

    // R11: level source gone low before completion
    set_src(src & ~31'h8);
    wr(a_clm(0), 4);
    idle();
    rd(a_clm(0), got); chk("R11 no rerequest", got, 0);
    chk("R11 irq low", 32'(irq[0]), 0);

    // R12: edge source 20
    wr(a_en(0), 32'h1 << 20);
    set_src(src | 31'h8_0000);
    idle();
    chk("R12 irq on edge", 32'(irq[0]), 1);
    rd(a_clm(0), got); chk("R12 claim", got, 20);
    wr(a_clm(0), 20);
    idle();
    rd(a_clm(0), got); chk("R12 held high", got, 0);
    set_src(src & ~31'h8_0000);
    set_src(src | 31'h8_0000);
    rd(a_clm(0), got); chk("R12 new edge", got, 20);
    set_src(src & ~31'h8_0000);
    set_src(src | 31'h8_0000);
    wr(a_clm(0), 20);
    idle();
    rd(a_clm(0), got); chk("R12 edge in service dropped", got, 0);
    set_src(src & ~31'h8_0000);
    set_src(src | 31'h8_0000);
    rd(a_clm(0), got); chk("R12 edge after service", got, 20);
    wr(a_clm(0), 20);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule